// File: doc/BRIEF.md
# Audio Sample FIFO Threshold Interrupt Controller

This block holds the transmit and receive sample queues of a serial audio port and tells software when to service them. Software fills the transmit queue and drains the receive queue through a small word-addressed register bus. The same bus is used to program fill thresholds and interrupt enables, to read status, to start or stop each direction, and to flush either queue. The serializers connect on the other side. The transmit serializer requests one word at a time. The receive serializer pushes one word at a time.

Two interrupt sources follow the fill levels. One is raised while the transmit queue has drained to its threshold or below. The other is raised while the receive queue has filled to its threshold or above. A third, sticky source records a transmit underrun. Each threshold is programmed as its value minus one. A flush request empties its queue at once. The flush bit then reads back as busy for a fixed two cycles, so software can poll it for completion.

Top module: `audio_fifo_irq_ctrl`

## Requirements
- R1: Each queue holds DEPTH (32) words, first in, first out. The transmit level reads at word address 0 and the receive level at address 1, in bits [5:0]. A write to the transmit data address (6) while the transmit queue is full is dropped.
- R2: The interrupt control register at address 2 reads back the following fields: transmit-low enable at bit 0, receive-high enable at bit 16, transmit threshold minus one in bits [8:4], and receive threshold minus one in bits [24:20]. Writing 1 to bit 2 clears the underrun flag, and bit 2 always reads 0.
- R3: The status register at address 3 holds three flags. Bit 0 is 1 while the transmit level is less than or equal to the transmit threshold. Bit 16 is 1 while the receive level is greater than or equal to the receive threshold. Bit 1 is the underrun flag.
- R4: `irq` is (status bit 0 AND enable bit 0) OR (status bit 16 AND enable bit 16) OR the underrun flag.
- R5: The underrun flag is set when `tx_req` is high while transmit is started and the transmit queue is empty. It stays set until it is cleared through R2. A request while transmit is stopped never sets it.
- R6: The transfer register at address 4 reads back two bits: bit 0 starts transmit and bit 1 starts receive. While transmit is stopped, `tx_req` removes nothing. While receive is stopped, `rx_push` words are dropped. Writing 0 stops both directions.
- R7: The clear register at address 5 flushes the transmit queue through bit 0 and the receive queue through bit 1. The level reads 0 in the cycle after the write. The bit reads 1 for exactly two cycles and then returns to 0 by itself.
- R8: While a flush of a queue is busy, pushes into that queue are ignored. For transmit these are bus data writes; for receive they are `rx_push` words.
- R9: A read of address 7 returns the oldest receive word and removes it, and it returns 0 when the queue is empty. `tx_data` shows the oldest transmit word, and `tx_valid` is 1 while the transmit queue holds data and is not being flushed.
- R10: After reset, both levels are 0 and both directions are stopped. All enables and threshold fields are 0, so both thresholds are 1. No flush is busy and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_req | input | 1 | Transmit serializer requests a word |
| tx_data | output | DW | Oldest transmit word |
| tx_valid | output | 1 | Transmit queue has a word to give |
| rx_push | input | 1 | Receive serializer delivers a word |
| rx_data | input | DW | Word being delivered |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker checks several behaviours on every cycle. Both levels stay within DEPTH. A clear write empties its queue on the next cycle, and a busy flush ends by itself two cycles after the last clear write. Any push attempted during a flush leaves the level at 0. The underrun flag is set by an empty-queue request and holds until cleared, and `irq` never rises without an enable or an underrun. Some properties only the bench scenarios can show: word ordering through both queues, the exact threshold crossings in the status register, and stopped directions ignoring their serializer. The bench also shows register read-back values, the full-queue drop and the zero returned by an empty receive read.

// File: rtl/audio_fifo_irq_ctrl.sv
module audio_fifo_irq_ctrl #(
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tx_req,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int TXTH_LSB = 4;
  localparam int RXTH_LSB = 20;
  localparam logic [1:0] FLUSH_CYC = 2'd2;
  localparam logic [2:0] A_TXLVL = 3'd0, A_RXLVL = 3'd1, A_ICTL = 3'd2, A_ISTAT = 3'd3,
                         A_XFER = 3'd4, A_CLR = 3'd5, A_TXD = 3'd6, A_RXD = 3'd7;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic [1:0]    tx_fl, rx_fl;
  logic [AW-1:0] tx_thm1, rx_thm1;
  logic          tx_run, rx_run, txe_en, rxf_en, udr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire wr        = bus_en & bus_we;
  wire rd        = bus_en & ~bus_we;
  wire wr_ictl   = wr && (bus_addr == A_ICTL);
  wire tx_clr_wr = wr && (bus_addr == A_CLR) && bus_wdata[0];
  wire rx_clr_wr = wr && (bus_addr == A_CLR) && bus_wdata[1];
  wire tx_busy   = (tx_fl != 2'd0);
  wire rx_busy   = (rx_fl != 2'd0);
  wire tx_empty  = (tx_lvl == '0);
  wire rx_empty  = (rx_lvl == '0);

  wire tx_push_ok = wr && (bus_addr == A_TXD) && !tx_busy && (tx_lvl != LW'(DEPTH));
  wire tx_pop_ok  = tx_req && tx_run && !tx_empty && !tx_busy;
  wire rx_push_ok = rx_push && rx_run && !rx_busy && (rx_lvl != LW'(DEPTH));
  wire rx_pop_ok  = rd && (bus_addr == A_RXD) && !rx_empty && !rx_busy;
  wire udr_hit    = tx_req && tx_run && tx_empty && !tx_busy;

  wire txe_st = (tx_lvl <= (LW'(tx_thm1) + LW'(1)));
  wire rxf_st = (rx_lvl >= (LW'(rx_thm1) + LW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0; tx_fl <= 2'd0;
    end else if (tx_clr_wr) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0; tx_fl <= FLUSH_CYC;
    end else if (tx_busy) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0; tx_fl <= tx_fl - 2'd1;
    end else begin
      if (tx_push_ok) tx_wp <= nxt(tx_wp);
      if (tx_pop_ok)  tx_rp <= nxt(tx_rp);
      tx_lvl <= tx_lvl + LW'(tx_push_ok) - LW'(tx_pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0; rx_fl <= 2'd0;
    end else if (rx_clr_wr) begin
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0; rx_fl <= FLUSH_CYC;
    end else if (rx_busy) begin
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0; rx_fl <= rx_fl - 2'd1;
    end else begin
      if (rx_push_ok) rx_wp <= nxt(rx_wp);
      if (rx_pop_ok)  rx_rp <= nxt(rx_rp);
      rx_lvl <= rx_lvl + LW'(rx_push_ok) - LW'(rx_pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push_ok) tx_mem[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_push_ok) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txe_en <= 1'b0; rxf_en <= 1'b0; tx_thm1 <= '0; rx_thm1 <= '0;
      tx_run <= 1'b0; rx_run <= 1'b0; udr <= 1'b0;
    end else begin
      if (wr_ictl) begin
        txe_en  <= bus_wdata[0];
        rxf_en  <= bus_wdata[16];
        tx_thm1 <= bus_wdata[TXTH_LSB +: AW];
        rx_thm1 <= bus_wdata[RXTH_LSB +: AW];
      end
      if (wr && (bus_addr == A_XFER)) begin
        tx_run <= bus_wdata[0];
        rx_run <= bus_wdata[1];
      end
      if (udr_hit)                      udr <= 1'b1;
      else if (wr_ictl && bus_wdata[2]) udr <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TXLVL: bus_rdata[LW-1:0] = tx_lvl;
      A_RXLVL: bus_rdata[LW-1:0] = rx_lvl;
      A_ICTL: begin
        bus_rdata[0]  = txe_en;
        bus_rdata[16] = rxf_en;
        bus_rdata[TXTH_LSB +: AW] = tx_thm1;
        bus_rdata[RXTH_LSB +: AW] = rx_thm1;
      end
      A_ISTAT: begin
        bus_rdata[0]  = txe_st;
        bus_rdata[1]  = udr;
        bus_rdata[16] = rxf_st;
      end
      A_XFER: bus_rdata[1:0] = {rx_run, tx_run};
      A_CLR:  bus_rdata[1:0] = {rx_busy, tx_busy};
      A_RXD:  if (!rx_empty && !rx_busy) bus_rdata[DW-1:0] = rx_mem[rx_rp];
      default: bus_rdata = '0;
    endcase
  end

  assign tx_data  = tx_mem[tx_rp];
  assign tx_valid = !tx_empty && !tx_busy;
  assign irq      = (txe_st & txe_en) | (rxf_st & rxf_en) | udr;
endmodule

// File: rtl/audio_fifo_irq_chk.sv
module audio_fifo_irq_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [2:0]    bus_addr,
  input logic [2:0]    wbits,
  input logic          tx_req,
  input logic          irq,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic          tx_busy,
  input logic          rx_busy,
  input logic          tx_run,
  input logic          udr,
  input logic          txe_en,
  input logic          rxf_en
);
  wire clr_acc = bus_en && bus_we && (bus_addr == 3'd5);
  wire tx_clr  = clr_acc && wbits[0];
  wire rx_clr  = clr_acc && wbits[1];
  wire udr_clr = bus_en && bus_we && (bus_addr == 3'd2) && wbits[2];

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr || rx_clr) |=> ((tx_lvl == '0) || !$past(tx_clr)) && ((rx_lvl == '0) || !$past(rx_clr)));

  assert_flush_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy) && !tx_clr) |=> !tx_busy);

  assert_flush_drops_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> (tx_lvl == '0));

  assert_flush_drops_rxpush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> (rx_lvl == '0));

  assert_underrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_run && (tx_lvl == '0) && !tx_busy) |=> udr);

  assert_underrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (udr && !udr_clr) |=> udr);

  assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (txe_en || rxf_en || udr));
endmodule

bind audio_fifo_irq_ctrl audio_fifo_irq_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .wbits(bus_wdata[2:0]), .tx_req(tx_req), .irq(irq), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_run(tx_run), .udr(udr),
  .txe_en(txe_en), .rxf_en(rxf_en)
);

// File: tb/sim_audio_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_audio_fifo_irq_ctrl;
  localparam int DW = 32;
  localparam logic [2:0] A_TXLVL = 3'd0, A_RXLVL = 3'd1, A_ICTL = 3'd2, A_ISTAT = 3'd3,
                         A_XFER = 3'd4, A_CLR = 3'd5, A_TXD = 3'd6, A_RXD = 3'd7;
  localparam int NV = 11;
  // {read?, addr, write data, expected read data}
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, A_ICTL,  32'h0021_0031, 32'h0},
    {1'b1, A_ICTL,  32'h0,         32'h0021_0031},
    {1'b1, A_ISTAT, 32'h0,         32'h0000_0001},
    {1'b0, A_TXD,   32'h0000_00A0, 32'h0},
    {1'b0, A_TXD,   32'h0000_00A1, 32'h0},
    {1'b0, A_TXD,   32'h0000_00A2, 32'h0},
    {1'b0, A_TXD,   32'h0000_00A3, 32'h0},
    {1'b0, A_TXD,   32'h0000_00A4, 32'h0},
    {1'b1, A_TXLVL, 32'h0,         32'h0000_0005},
    {1'b1, A_ISTAT, 32'h0,         32'h0000_0000},
    {1'b1, A_XFER,  32'h0,         32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_req = 1'b0, tx_valid, rx_push = 1'b0, irq;
  logic [DW-1:0] tx_data, rx_data = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_fifo_irq_ctrl #(.DEPTH(32), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_req(tx_req), .tx_data(tx_data),
    .tx_valid(tx_valid), .rx_push(rx_push), .rx_data(rx_data), .irq(irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_en = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [31:0] exp, input string what);
    logic [31:0] d;
    rd(a, d);
    check(d, exp, what);
  endtask

  task automatic pop();
    @(negedge clk); tx_req = 1'b1;
    @(posedge clk); #1 tx_req = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk); rx_push = 1'b1; rx_data = d;
    @(posedge clk); #1 rx_push = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check({31'd0, irq}, 32'd0, "R10 irq after reset");
    check({31'd0, tx_valid}, 32'd0, "R10 tx_valid after reset");
    rdchk(A_ISTAT, 32'h1, "R10 status after reset (threshold 1)");
    rdchk(A_ICTL, 32'h0, "R10 control after reset");
    rdchk(A_CLR, 32'h0, "R10 no flush busy");
    rdchk(A_RXLVL, 32'h0, "R10 rx level");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) begin
        rd(VEC[i][66:64], d);
        check(d, VEC[i][31:0], $sformatf("R1 R2 R3 R6 table step %0d", i));
      end else begin
        wr(VEC[i][66:64], VEC[i][63:32]);
      end
    end

    @(negedge clk);
    check({31'd0, irq}, 32'd0, "R4 irq low above threshold");
    pop();
    rdchk(A_TXLVL, 32'd5, "R6 stopped tx ignores request");
    rdchk(A_ISTAT, 32'h0, "R5 no underrun while stopped");

    wr(A_XFER, 32'h1);
    @(negedge clk);
    check({31'd0, tx_valid}, 32'd1, "R9 tx_valid");
    check(tx_data, 32'hA0, "R9 oldest tx word");
    pop();
    @(negedge clk);
    check({31'd0, irq}, 32'd1, "R4 R3 irq at level equal to threshold");
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      check(tx_data, 32'hA0 + k, "R1 tx order");
      pop();
    end
    rdchk(A_TXLVL, 32'd0, "R1 tx drained");
    pop();
    rdchk(A_ISTAT, 32'h3, "R5 underrun set");
    rdchk(A_ISTAT, 32'h3, "R5 underrun sticky");
    wr(A_ICTL, 32'h0021_0035);
    rdchk(A_ISTAT, 32'h1, "R2 underrun cleared");
    rdchk(A_ICTL, 32'h0021_0031, "R2 clear bit reads zero");

    push(32'h99);
    rdchk(A_RXLVL, 32'd0, "R6 stopped rx drops word");
    wr(A_XFER, 32'h3);
    push(32'h11); push(32'h22); push(32'h33);
    rdchk(A_RXLVL, 32'd3, "R1 rx level");
    rdchk(A_ISTAT, 32'h1_0001, "R3 rx at threshold");
    @(negedge clk);
    check({31'd0, irq}, 32'd1, "R4 irq from rx");
    rdchk(A_RXD, 32'h11, "R9 oldest rx word");
    rdchk(A_RXLVL, 32'd2, "R9 rx read removes word");
    rdchk(A_ISTAT, 32'h1, "R3 rx below threshold");

    wr(A_XFER, 32'h0);
    rdchk(A_XFER, 32'h0, "R6 zero stops both");
    push(32'h44);
    rdchk(A_RXLVL, 32'd2, "R6 rx stopped after zero write");

    for (int k = 0; k < 33; k++) wr(A_TXD, 32'h100 + k);
    rdchk(A_TXLVL, 32'h20, "R1 full level, extra write dropped");

    wr(A_CLR, 32'h1);
    rdchk(A_CLR, 32'h1, "R7 flush busy");
    wr(A_TXD, 32'h55);
    rdchk(A_CLR, 32'h0, "R7 flush self-cleared");
    rdchk(A_TXLVL, 32'd0, "R8 write during flush ignored");

    wr(A_XFER, 32'h2);
    wr(A_CLR, 32'h2);
    push(32'h66);
    push(32'h77);
    rdchk(A_RXLVL, 32'd0, "R8 rx push during flush ignored");
    rdchk(A_CLR, 32'h0, "R7 rx flush self-cleared");
    push(32'h88);
    rdchk(A_RXD, 32'h88, "R9 rx after flush");
    rdchk(A_RXD, 32'h0, "R9 empty rx read returns zero");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule